// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers up to 32 interrupt request lines into a single request towards a processor. Each line is first brought into the clock domain by a synchronizer. It is then latched into a status word. Every line is either edge- or level-sensitive, and that choice is made by a parameter when the block is built. Software reaches the block over a plain 32-bit register bus with single-cycle write and read strobes, a byte address and a data word. Reads return data in the same cycle as the read strobe.

The status word is masked by a per-line enable word to form a pending word. The interrupt output is raised when at least one bit is pending and the output-enable bit of a small master control field is set. Software can change enable bits one at a time, without a read-modify-write, through separate set and clear aliases. It retires requests by writing ones to an acknowledge location. It reads the number of the line to serve from a vector location, which gives priority to the lowest-numbered pending line.

Top module: `intr_hub`

## Requirements
- R1: After reset the status, enable and master control words read as 0, the vector reads as 0xFFFFFFFF and `irq_o` is low.
- R2: A write to byte address 8 replaces the whole enable word, and a read of address 8 returns it. Address bits [1:0] are ignored.
- R3: A write to address 16 ORs the written one bits into the enable word. Zero bits leave their enable bits unchanged.
- R4: A write to address 20 clears the enable bits where the written word has ones, and leaves the others unchanged.
- R5: Lines whose bit in `LEVEL_MASK` is 0 are edge-sensitive (by default lines 0 to 15). A rising edge on the synchronized input sets the status bit, which is readable at address 0 three clock edges after the input rises. The bit stays set after the input falls.
- R6: Lines whose bit in `LEVEL_MASK` is 1 are level-sensitive (by default lines 16 to 31). Their status bit is set while the synchronized input is high. An acknowledge while the input is still high leaves the bit set. Once the input is low, the bit stays set until it is acknowledged.
- R7: Writing to address 12 clears the status bits where the word has ones, and leaves the other status bits unchanged. Writing 0xFFFFFFFF clears every status bit.
- R8: A read of address 4 returns status AND enable.
- R9: `irq_o` is high exactly when master bit 0 is 1 and the pending word is nonzero.
- R10: A read of address 24 returns the index of the lowest-numbered pending bit, or 0xFFFFFFFF when nothing is pending.
- R11: Address 28 holds a 2-bit master field and reads back as {30'b0, field}. Bit 0 gates `irq_o`. Bit 1 enables capture: while it is 0, no input sets a status bit.
- R12: If an acknowledge write and a new capture event hit the same line on the same clock edge, the event wins and the status bit stays set.
- R13: Writes to addresses 0, 4 and 24 have no effect. Reads of addresses 12, 16 and 20 return 0, and any read returns 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt request lines, asynchronous to clk |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The enable word is driven by plain writes, by set and clear writes with overlapping patterns, and by zero bits that must not disturb it. This shows that a full replace and the two aliases are three different operations. Edge lines and level lines are pulsed, held and acknowledged while high, and the two kinds are told apart by whether an acknowledge sticks. Pending patterns with several bits set, with the lowest bit masked off and then retired, show that the vector picks the lowest pending bit and not the lowest status bit. An acknowledge is timed onto the exact edge where a new event lands, which separates the "event wins" priority from the opposite one.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;

  localparam int unsigned REG_W = 32;

  // word index = byte address [4:2]; the order is the register map
  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_PEND   = 3'd1,
    RG_ENABLE = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VECTOR = 3'd6,
    RG_MASTER = 3'd7
  } reg_sel_e;

  // lowest set bit of a word, all ones when the word is zero
  function automatic logic [REG_W-1:0] lowest_set(input logic [REG_W-1:0] w);
    logic [REG_W-1:0] r;
    r = '1;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (w[i]) r = i[REG_W-1:0];
    end
    return r;
  endfunction

  // capture event wins over acknowledge
  function automatic logic [REG_W-1:0] status_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] ack,
                                                   input logic [REG_W-1:0] evt);
    return (cur & ~ack) | evt;
  endfunction

  function automatic logic [REG_W-1:0] enable_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] data,
                                                   input logic              do_load,
                                                   input logic              do_set,
                                                   input logic              do_clr);
    logic [REG_W-1:0] r;
    r = cur;
    if (do_load) r = data;
    if (do_set)  r = r | data;
    if (do_clr)  r = r & ~data;
    return r;
  endfunction

endpackage

// File: rtl/intr_hub_sense.sv
module intr_hub_sense #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] req_o
);

  logic [NUM_SRC-1:0] stage_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= src_i;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[SYNC_STAGES-1];
    end
  end

  assign line_s = stage_q[SYNC_STAGES-1];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    if (LEVEL_MASK[g]) begin : g_level
      assign req_o[g] = line_s[g];
    end else begin : g_edge
      assign req_o[g] = line_s[g] & ~prev_q[g];
    end
  end

endmodule

// File: rtl/intr_hub_regs.sv
module intr_hub_regs
  import intr_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_load,
  input  logic               wr_set,
  input  logic               wr_clr,
  input  logic               wr_ack,
  input  logic               wr_master,
  input  logic [REG_W-1:0]   wdata,
  output logic [NUM_SRC-1:0] set_ev,
  output logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] enable_q,
  output logic [1:0]         master_q
);

  logic [REG_W-1:0] stat_w, en_w, ack_w, ev_w, stat_n, en_n;

  assign set_ev   = req_i & {NUM_SRC{master_q[1]}};
  assign ack_mask = wr_ack ? wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    stat_w = '0; stat_w[NUM_SRC-1:0] = status_q;
    en_w   = '0; en_w[NUM_SRC-1:0]   = enable_q;
    ack_w  = '0; ack_w[NUM_SRC-1:0]  = ack_mask;
    ev_w   = '0; ev_w[NUM_SRC-1:0]   = set_ev;
    stat_n = status_next(stat_w, ack_w, ev_w);
    en_n   = enable_next(en_w, wdata, wr_load, wr_set, wr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= '0;
    end else begin
      status_q <= stat_n[NUM_SRC-1:0];
      enable_q <= en_n[NUM_SRC-1:0];
      if (wr_master) master_q <= wdata[1:0];
    end
  end

endmodule

// File: rtl/intr_hub_prio.sv
module intr_hub_prio
  import intr_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] pending_i,
  output logic [REG_W-1:0]   vec_o
);

  logic [REG_W-1:0] pend_w;

  always_comb begin
    pend_w = '0;
    pend_w[NUM_SRC-1:0] = pending_i;
    vec_o = lowest_set(pend_w);
  end

endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 32'hFFFF_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [4:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               irq_o
);

  reg_sel_e           sel;
  logic               wr_load, wr_set, wr_clr, wr_ack, wr_master;
  logic [NUM_SRC-1:0] req, set_ev, ack_mask, status_q, enable_q, pending;
  logic [1:0]         master_q;
  logic [REG_W-1:0]   vec_word;
  logic [1:0]         unused_addr_lsb;

  assign sel             = reg_sel_e'(addr[4:2]);
  assign unused_addr_lsb = addr[1:0];

  assign wr_load   = wr_en && (sel == RG_ENABLE);
  assign wr_set    = wr_en && (sel == RG_SETEN);
  assign wr_clr    = wr_en && (sel == RG_CLREN);
  assign wr_ack    = wr_en && (sel == RG_ACK);
  assign wr_master = wr_en && (sel == RG_MASTER);

  intr_hub_sense #(
    .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES), .LEVEL_MASK(LEVEL_MASK)
  ) u_sense (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_o(req)
  );

  intr_hub_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .wr_load(wr_load), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_ack(wr_ack), .wr_master(wr_master), .wdata(wdata),
    .set_ev(set_ev), .ack_mask(ack_mask),
    .status_q(status_q), .enable_q(enable_q), .master_q(master_q)
  );

  assign pending = status_q & enable_q;

  intr_hub_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .pending_i(pending), .vec_o(vec_word)
  );

  assign irq_o = master_q[0] & (|pending);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        RG_STATUS: rdata[NUM_SRC-1:0] = status_q;
        RG_PEND:   rdata[NUM_SRC-1:0] = pending;
        RG_ENABLE: rdata[NUM_SRC-1:0] = enable_q;
        RG_VECTOR: rdata = vec_word;
        RG_MASTER: rdata[1:0] = master_q;
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk #(
  parameter int unsigned NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               wr_set,
  input logic               wr_clr,
  input logic               wr_ack,
  input logic [31:0]        wdata,
  input logic [NUM_SRC-1:0] set_ev,
  input logic [NUM_SRC-1:0] ack_mask,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic [NUM_SRC-1:0] pending,
  input logic [1:0]         master_q,
  input logic [31:0]        vec_word
);

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  assert_seten_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((enable_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

  assert_clren_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((enable_q & $past(wdata[NUM_SRC-1:0])) == '0));

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((status_q & $past(ack_mask & ~set_ev)) == '0));

  assert_master_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q[0] |-> !irq_o);

  assert_pending_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q[0] && (pending != '0)) |-> irq_o);

  assert_vec_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vec_word == '1));

  assert_vec_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> ((vec_word < NUM_SRC) && pending[vec_word[IDX_W-1:0]]));

  assert_capture_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q[1] |=> ((status_q & ~$past(status_q)) == '0));

  assert_edge_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((status_q & $past(set_ev)) == $past(set_ev)));

endmodule

bind intr_hub intr_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o),
  .wr_set(wr_set), .wr_clr(wr_clr), .wr_ack(wr_ack), .wdata(wdata),
  .set_ev(set_ev), .ack_mask(ack_mask), .status_q(status_q),
  .enable_q(enable_q), .pending(pending), .master_q(master_q),
  .vec_word(vec_word)
);

// File: tb/test_intr_hub.sv
`timescale 1ns/1ps
module test_intr_hub;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, probe = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #10 clk = ~clk;

  intr_hub i_intr_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_status = '0, m_enable = '0;
  logic        m_out_en = 1'b0;

  // monitor
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    if (rd_en || probe) begin
      n_vec++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual=%h expected=<item>", rdata);
      end else begin
        it  = sbq.pop_front();
        act = it.is_irq ? {31'b0, irq} : rdata;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] want_vec(input logic [31:0] p);
    int k = 0;
    while (k < 32 && !p[k]) k++;
    return (k == 32) ? 32'hFFFF_FFFF : 32'(k);
  endfunction

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = t;
    sbq.push_back(it);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = t;
    sbq.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic check_model(input string t);
    logic [31:0] p;
    p = m_status & m_enable;
    rd(5'd0,  m_status, {t, " status"});
    rd(5'd4,  p,        {"R8 ", t, " pending"});
    rd(5'd24, want_vec(p), {"R10 ", t, " vector"});
    chk_irq(m_out_en && (p != 0), {"R9 ", t, " irq"});
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL all-reqs watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(5'd0,  32'h0, "R1 status");
    rd(5'd8,  32'h0, "R1 enable");
    rd(5'd28, 32'h0, "R1 master");
    rd(5'd24, 32'hFFFF_FFFF, "R1 vector");

    // R11 capture off: edge on line 3 ignored
    src[3] = 1'b1; idle(5); src[3] = 1'b0; idle(4);
    rd(5'd0, 32'h0, "R11 no capture while bit1=0");

    wr(5'd28, 32'h3); m_out_en = 1'b1;
    rd(5'd28, 32'h3, "R11 master readback");

    // R2 enable replace, lsb of address ignored
    wr(5'd8, 32'hA5A5_0F0F);
    rd(5'd8, 32'hA5A5_0F0F, "R2 enable load");
    wr(5'd11, 32'h0);
    rd(5'd8, 32'h0, "R2 enable cleared via addr 11");

    // R3 / R4 aliases
    wr(5'd16, 32'h0000_0018);
    wr(5'd16, 32'h8000_0001);
    rd(5'd8, 32'h8000_0019, "R3 set-enable OR");
    wr(5'd20, 32'h0000_0011);
    rd(5'd8, 32'h8000_0008, "R4 clear-enable");
    m_enable = 32'h8000_0008;

    // R5 edge line 3
    src[3] = 1'b1; idle(4); src[3] = 1'b0; idle(4);
    m_status[3] = 1'b1;
    check_model("R5 edge line3 latched");

    // edge line 5 while disabled, then enable, then mask 3
    src[5] = 1'b1; idle(4); src[5] = 1'b0; idle(4);
    m_status[5] = 1'b1;
    check_model("R5 line5 masked");
    wr(5'd16, 32'h20); m_enable[5] = 1'b1;
    check_model("R10 two pending");
    wr(5'd20, 32'h8); m_enable[3] = 1'b0;
    check_model("R10 lower masked off");

    // R9 master bit 0
    wr(5'd28, 32'h2); m_out_en = 1'b0;
    chk_irq(1'b0, "R9 irq gated by master bit0");
    wr(5'd28, 32'h3); m_out_en = 1'b1;
    chk_irq(1'b1, "R9 irq with master bit0");

    // R7 acknowledge only selected bits
    wr(5'd12, 32'h8); m_status[3] = 1'b0;
    check_model("R7 ack line3 only");

    // R6 level line 20
    src[20] = 1'b1; idle(4);
    m_status[20] = 1'b1;
    rd(5'd0, m_status, "R6 level latched");
    wr(5'd12, 32'h0010_0000);
    idle(1);
    rd(5'd0, m_status, "R6 ack while high has no effect");
    src[20] = 1'b0; idle(4);
    rd(5'd0, m_status, "R6 stays set after input low");
    wr(5'd12, 32'h0010_0000); m_status[20] = 1'b0;
    rd(5'd0, m_status, "R6 ack after input low");

    // R12 ack on the same edge as a new edge event (line 7)
    src[7] = 1'b1;
    idle(2);
    wr(5'd12, 32'h80);
    m_status[7] = 1'b1;
    rd(5'd0, m_status, "R12 event wins over ack");
    src[7] = 1'b0; idle(3);

    // R7 ack all
    wr(5'd12, 32'hFFFF_FFFF); m_status = '0;
    check_model("R7 ack all");

    // R13 read-only / write-only locations
    wr(5'd0,  32'hFFFF_FFFF);
    wr(5'd4,  32'hFFFF_FFFF);
    wr(5'd24, 32'h0);
    rd(5'd0,  32'h0, "R13 status not writable");
    rd(5'd24, 32'hFFFF_FFFF, "R13 vector not writable");
    rd(5'd8,  m_enable, "R13 enable untouched by ro writes");
    rd(5'd12, 32'h0, "R13 ack reads zero");
    rd(5'd16, 32'h0, "R13 set-enable reads zero");
    rd(5'd20, 32'h0, "R13 clear-enable reads zero");

    // R11 capture off for a level line, then on
    wr(5'd28, 32'h1);
    src[25] = 1'b1; idle(4);
    rd(5'd0, 32'h0, "R11 level line not captured");
    wr(5'd28, 32'h3); idle(1);
    m_status[25] = 1'b1;
    rd(5'd0, m_status, "R11 level line captured after bit1 set");
    src[25] = 1'b0;

    done = 1'b1;
    finish_run();
  end

endmodule